// File: doc/BRIEF.md
# Serial Receive Byte Queue with Threshold and Idle Timeout

This block buffers incoming serial bytes between the line receiver and the CPU. The receiver offers one byte per frame tick on a valid strobe. The CPU removes bytes one at a time with a read request. A read request can also ask for the threshold flags to be released. The queue holds up to sixteen bytes and reports how many it currently holds.

Two flags tell software when to come and empty the queue. The threshold flag rises when a stored byte brings the fill level up to a programmable level, chosen from four values. The idle flag covers a small amount of data that stays below that level. It rises when the queue is non-empty and below the threshold and the line has delivered nothing for two frame ticks in a row. Either event also produces a one-cycle request pulse for a DMA engine. A byte offered while the queue is full is dropped and latches an overrun flag. While that flag is set, the receiver path is closed. The policy for clearing status and the routing of interrupts belong to the surrounding controller. This block only exposes flags and interrupt-level outputs that are gated by enable inputs.

Top module: `rx_byte_queue`

## Requirements
- R1: Bytes are returned in arrival order. A read request with a non-empty queue presents the oldest byte on `rd_data` after the next rising clock edge. The queue holds at most 16 bytes, and `fill_cnt` never exceeds 16.
- R2: `thr_sel` selects the threshold: code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14. When a stored byte brings the level to the threshold or above, `thr_flag` is set and `dma_req` is high for exactly the following cycle.
- R3: A byte offered while 16 bytes are held is discarded and sets `ovr_flag`. `ovr_flag` stays set until `ovr_clr`. While it is set, offered bytes are ignored. `err_irq` equals `ovr_flag` AND `err_ie`.
- R4: On a frame tick that carries no byte, `idle_flag` is set and `dma_req` pulses for one cycle when all of these hold: the previous frame tick also carried no byte, the queue is non-empty, and the level is below the threshold.
- R5: A read with `rd_clr` high clears `thr_flag` if the level left after it is below the threshold, and clears `idle_flag` if the queue is left empty. A read with `rd_clr` low leaves both flags unchanged.
- R6: `q_flush` empties the queue, returns `fill_cnt` to 0 and clears `thr_flag` and `idle_flag`. It does not clear `ovr_flag`.
- R7: `fill_cnt` reports the number of bytes held one cycle after each push, pop or flush. After reset it is 0, and all flags and `rd_data` are 0.
- R8: A read of an empty queue puts 0 on `rd_data` and changes no flag and no count.
- R9: With `rx_en` low, offered bytes are ignored. They do not change the count and do not set `ovr_flag`.
- R10: `rx_irq` equals (`thr_flag` OR `idle_flag`) AND `rx_ie`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable |
| frame_tick | input | 1 | One-cycle pulse per frame time |
| rx_valid | input | 1 | A byte is offered on this frame tick |
| rx_data | input | 8 | Offered byte |
| rd_req | input | 1 | CPU read request (pop) |
| rd_clr | input | 1 | With `rd_req`: release flags per R5 |
| thr_sel | input | 2 | Threshold code (R2) |
| q_flush | input | 1 | Empty the queue |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rd_data | output | 8 | Byte returned by the last read |
| fill_cnt | output | 5 | Number of bytes held |
| thr_flag | output | 1 | Threshold reached |
| idle_flag | output | 1 | Data waiting below threshold after line idle |
| ovr_flag | output | 1 | Overrun latched |
| dma_req | output | 1 | One-cycle DMA request |
| rx_irq | output | 1 | Receive interrupt level |
| err_irq | output | 1 | Error interrupt level |

## Verification
The idle flag is the hardest state to reach. It needs a specific history of frame ticks: at least one byte has arrived, and the level has stayed below the threshold. Then two consecutive ticks carry no byte, with the flag checked clear after the first idle tick and set after the second. The bench sets the threshold to eight and delivers two bytes on consecutive ticks. It then issues two empty ticks and checks both the flag and the one-cycle DMA pulse at each step. It then drains the queue with flag-clearing reads to observe when the flag is released.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    THR_1  = 2'd0,
    THR_4  = 2'd1,
    THR_8  = 2'd2,
    THR_14 = 2'd3
  } thr_code_e;

  // Map a threshold code to a byte level.
  function automatic int unsigned thr_level(input logic [1:0] code);
    case (thr_code_e'(code))
      THR_1:   thr_level = 1;
      THR_4:   thr_level = 4;
      THR_8:   thr_level = 8;
      default: thr_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          zero,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  // Write port: no reset, so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; an empty read loads zero instead.
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (re)   q <= mem[raddr];
    else if (zero) q <= '0;
  end

endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] nxt_cnt
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    step = (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (flush) nxt_cnt = '0;
    else       nxt_cnt = cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      cnt <= nxt_cnt;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CAP);
  // R6
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst) flush |=> (cnt == '0));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          arrive,
  input  logic          push,
  input  logic          drop,
  input  logic          pop,
  input  logic          pop_clr,
  input  logic          flush,
  input  logic          ovr_clr,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] nxt_cnt,
  output logic          thr_f,
  output logic          idle_f,
  output logic          ovr_f,
  output logic          dma
);

  logic last_arr;
  logic reach, idle_set, rel_thr, rel_idle;

  always_comb begin
    reach    = push && (nxt_cnt >= thr);
    idle_set = tick && !arrive && !last_arr && (nxt_cnt != '0) &&
               (nxt_cnt < thr) && !idle_f;
    rel_thr  = pop && pop_clr && (nxt_cnt < thr);
    rel_idle = pop && pop_clr && (nxt_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_arr <= 1'b0;
      thr_f    <= 1'b0;
      idle_f   <= 1'b0;
      ovr_f    <= 1'b0;
      dma      <= 1'b0;
    end else begin
      if (tick) last_arr <= arrive;
      dma <= !flush && (reach || idle_set);
      if (flush) begin
        thr_f  <= 1'b0;
        idle_f <= 1'b0;
      end else begin
        if (reach)        thr_f <= 1'b1;
        else if (rel_thr) thr_f <= 1'b0;
        if (rel_idle)      idle_f <= 1'b0;
        else if (idle_set) idle_f <= 1'b1;
      end
      if (drop)         ovr_f <= 1'b1;
      else if (ovr_clr) ovr_f <= 1'b0;
    end
  end

  // R2
  reach_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !flush && nxt_cnt >= thr) |=> (thr_f && dma));
  // R3
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_f && !ovr_clr) |=> ovr_f);
  // R4
  idle_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_f) |-> ($past(tick) && !$past(arrive)));

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          frame_tick,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rd_req,
  input  logic          rd_clr,
  input  logic [1:0]    thr_sel,
  input  logic          q_flush,
  input  logic          ovr_clr,
  input  logic          rx_ie,
  input  logic          err_ie,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill_cnt,
  output logic          thr_flag,
  output logic          idle_flag,
  output logic          ovr_flag,
  output logic          dma_req,
  output logic          rx_irq,
  output logic          err_irq
);

  import rxq_pkg::*;

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          offer, full, empty, push_w, drop_w, pop_w;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] nxt_cnt, thr;

  always_comb begin
    full   = (fill_cnt == CAP);
    empty  = (fill_cnt == '0);
    offer  = frame_tick && rx_valid && rx_en && !ovr_flag && !q_flush;
    push_w = offer && !full;
    drop_w = offer && full;
    pop_w  = rd_req && !empty && !q_flush;
    thr    = CW'(thr_level(thr_sel));
    rx_irq  = rx_ie && (thr_flag || idle_flag);
    err_irq = err_ie && ovr_flag;
  end

  rxq_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst), .flush(q_flush), .push(push_w), .pop(pop_w),
    .wptr(wptr), .rptr(rptr), .cnt(fill_cnt), .nxt_cnt(nxt_cnt)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .we(push_w), .waddr(wptr), .wdata(rx_data),
    .re(pop_w), .raddr(rptr), .zero(rd_req && empty), .q(rd_data)
  );

  rxq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .tick(frame_tick), .arrive(offer),
    .push(push_w), .drop(drop_w), .pop(pop_w), .pop_clr(rd_clr),
    .flush(q_flush), .ovr_clr(ovr_clr), .thr(thr), .nxt_cnt(nxt_cnt),
    .thr_f(thr_flag), .idle_f(idle_flag), .ovr_f(ovr_flag), .dma(dma_req)
  );

  // R9
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rd_req && !q_flush) |=> $stable(fill_cnt));
  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty && !q_flush && !frame_tick) |=> (rd_data == '0 && $stable(thr_flag)));

endmodule

// File: tb/sim_rx_byte_queue.sv
`timescale 1ns/1ps
module sim_rx_byte_queue;

  logic       clk = 1'b0;
  logic       rst, rx_en, frame_tick, rx_valid, rd_req, rd_clr, q_flush, ovr_clr, rx_ie, err_ie;
  logic [7:0] rx_data, rd_data;
  logic [1:0] thr_sel;
  logic [4:0] fill_cnt;
  logic       thr_flag, idle_flag, ovr_flag, dma_req, rx_irq, err_irq;

  int n_chk = 0, n_fail = 0;
  bit m_ovr = 1'b0;
  logic [7:0] sb [$];

  always #4 clk = ~clk;

  rx_byte_queue u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .frame_tick(frame_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .rd_req(rd_req), .rd_clr(rd_clr), .thr_sel(thr_sel),
    .q_flush(q_flush), .ovr_clr(ovr_clr), .rx_ie(rx_ie), .err_ie(err_ie),
    .rd_data(rd_data), .fill_cnt(fill_cnt), .thr_flag(thr_flag), .idle_flag(idle_flag),
    .ovr_flag(ovr_flag), .dma_req(dma_req), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: offers one byte on a frame tick and records what should be stored.
  task automatic tick(input bit v, input logic [7:0] d);
    @(negedge clk);
    frame_tick = 1'b1; rx_valid = v; rx_data = d;
    if (v && rx_en && !m_ovr) begin
      if (sb.size() == 16) m_ovr = 1'b1;
      else sb.push_back(d);
    end
    @(negedge clk);
    frame_tick = 1'b0; rx_valid = 1'b0;
  endtask

  // Monitor side of the scoreboard: pops the expected byte and compares.
  task automatic rd(input bit clr, input string tag);
    logic [7:0] exp;
    exp = (sb.size() != 0) ? sb.pop_front() : 8'h00;
    @(negedge clk);
    rd_req = 1'b1; rd_clr = clr;
    @(negedge clk);
    rd_req = 1'b0; rd_clr = 1'b0;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_en = 1'b1; frame_tick = 1'b0; rx_valid = 1'b0; rx_data = '0;
    rd_req = 1'b0; rd_clr = 1'b0; thr_sel = 2'd0; q_flush = 1'b0; ovr_clr = 1'b0;
    rx_ie = 1'b1; err_ie = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check("R7 cnt", fill_cnt, 0);
    check("R7 flags", {thr_flag, idle_flag, ovr_flag, dma_req}, 0);
    check("R7 rd_data", rd_data, 0);

    // R2 code 0 -> level 1, with one-cycle DMA pulse; R10 interrupt
    tick(1'b1, 8'hA5);
    check("R2 thr code0", thr_flag, 1);
    check("R2 dma pulse", dma_req, 1);
    check("R10 rx_irq", rx_irq, 1);
    @(negedge clk);
    check("R2 dma one cycle", dma_req, 0);
    rd(1'b1, "R1 data");
    check("R5 thr released", thr_flag, 0);

    // R2 code 1 -> level 4
    thr_sel = 2'd1;
    for (int i = 0; i < 3; i++) tick(1'b1, 8'h10 + 8'(i));
    check("R2 below 4", thr_flag, 0);
    tick(1'b1, 8'h13);
    check("R2 at 4", thr_flag, 1);
    check("R7 cnt 4", fill_cnt, 4);
    rd(1'b0, "R1 order");
    check("R5 no clr keeps", thr_flag, 1);
    rd(1'b1, "R1 order");
    check("R5 clr below", thr_flag, 0);
    rd(1'b1, "R1 order");
    rd(1'b1, "R1 order");

    // R8 empty read
    rd(1'b1, "R8 empty data");
    check("R8 cnt", fill_cnt, 0);
    check("R8 flags", {thr_flag, idle_flag, ovr_flag}, 0);

    // R4 idle timeout with threshold 8
    thr_sel = 2'd2;
    tick(1'b1, 8'h21);
    tick(1'b1, 8'h22);
    tick(1'b0, 8'h00);
    check("R4 one idle tick", idle_flag, 0);
    tick(1'b0, 8'h00);
    check("R4 two idle ticks", idle_flag, 1);
    check("R4 dma", dma_req, 1);
    check("R10 idle irq", rx_irq, 1);
    rd(1'b1, "R1 order");
    check("R5 idle kept", idle_flag, 1);
    rd(1'b1, "R1 order");
    check("R5 idle cleared", idle_flag, 0);

    // R2 code 3 -> level 14, then R3 overrun
    thr_sel = 2'd3;
    for (int i = 0; i < 13; i++) tick(1'b1, 8'h40 + 8'(i));
    check("R2 below 14", thr_flag, 0);
    tick(1'b1, 8'h4D);
    check("R2 at 14", thr_flag, 1);
    tick(1'b1, 8'h4E);
    tick(1'b1, 8'h4F);
    check("R1 cnt 16", fill_cnt, 16);
    tick(1'b1, 8'hEE);
    check("R3 ovr", ovr_flag, 1);
    check("R3 err_irq", err_irq, 1);
    check("R3 dropped", fill_cnt, 16);
    rd(1'b0, "R1 order");
    tick(1'b1, 8'hEF);
    check("R3 blocked", fill_cnt, 15);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    m_ovr = 1'b0;
    check("R3 cleared", ovr_flag, 0);

    // R6 flush
    @(negedge clk); q_flush = 1'b1;
    @(negedge clk); q_flush = 1'b0;
    sb.delete();
    check("R6 cnt", fill_cnt, 0);
    check("R6 flags", {thr_flag, idle_flag}, 0);
    rd(1'b0, "R6 empty after flush");

    // R9 receiver disabled
    rx_en = 1'b0;
    tick(1'b1, 8'h77);
    check("R9 ignored", fill_cnt, 0);
    check("R9 no ovr", ovr_flag, 0);
    rx_en = 1'b1;

    // R1 order across pointer wrap
    thr_sel = 2'd3;
    for (int i = 0; i < 10; i++) tick(1'b1, 8'h90 + 8'(i));
    for (int i = 0; i < 10; i++) rd(1'b1, "R1 wrap order");
    check("R7 cnt drained", fill_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule